// File: doc/BRIEF.md
# Real-Time-Clock Dual Output Waveform Generator

This block drives two output pins of a real-time-clock domain. Each pin has its own 3-bit source code that picks what the pin shows: a steady low level, a square wave at 1 Hz, 32 Hz, 64 Hz or 512 Hz, a level that flips on every rising alarm edge, a straight copy of the alarm flag, or a pulse train. The pulse train's high time and its period are set by a 3-bit high-time code and a 2-bit period code, which both pins share.

Time is measured in half-ticks. The input `half_tick` is a one-cycle strobe in the system clock domain, raised once on each edge (both phases) of the 32768 Hz slow clock. One second is therefore 65536 half-ticks. All square waves are taken from one shared free-running half-tick count, so they stay phase-aligned with each other and across both pins. Counting half-ticks lets the shortest pulse be half of one slow-clock period. Each pin keeps its own pulse phase, which starts over whenever the pin enters pulse mode. Every output is registered.

Top module: `rtc_wave_out`

## Requirements
- R1: After reset both pins are 0. A pin whose source code is 0 stays at 0, whatever the alarm flag and half_tick do.
- R2: Let n be the number of half_tick strobes since reset, sampled one clock before the output. Codes 1, 2, 3 and 4 make the pin equal to bit 15, 10, 9 and 6 of n. These are 50% square waves at 1 Hz, 32 Hz, 64 Hz and 512 Hz, with half periods of 32768, 1024, 512 and 64 half-ticks.
- R3: Code 6 makes the pin equal to the alarm flag, with one clock of latency.
- R4: Code 5 shows a toggle state. The toggle state is 0 after reset and inverts on every 0-to-1 change of the alarm flag. The pin follows the alarm edge two clocks later.
- R5: Code 7 drives a pulse train. Let k be the half-ticks counted since the pin entered code 7. The pin is 1 while (k mod P) < H and 0 otherwise, one clock after the count.
- R6: The high-time code sets H in half-ticks: 0→2048, 1→1024, 2→256, 3→64, 4→32, 5→8, 6→2, 7→1.
- R7: The period code sets P in half-ticks: 0→65536, 1→32768, 2→16384, 3→8192.
- R8: Leaving code 7 clears that pin's pulse phase. On the clock after code 7 is entered again, the pin is 1, at the start of its high time.
- R9: The two pins are independent. Each pin's source code and pulse phase affect only that pin.
- R10: While half_tick is low, neither the shared count nor any pulse phase advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| half_tick | input | 1 | One-cycle strobe on each slow-clock edge |
| alarm_flag | input | 1 | Alarm flag, synchronous to clk |
| src_sel0 | input | 3 | Source code for pin 0 |
| src_sel1 | input | 3 | Source code for pin 1 |
| hi_code | input | 3 | Pulse high-time code (shared) |
| per_code | input | 2 | Pulse period code (shared) |
| pin_out0 | output | 1 | Pin 0 level |
| pin_out1 | output | 1 | Pin 1 level |

## Verification
Both pins are compared against an arithmetic model on every cycle while the bench sweeps through every source code.

- **Square waves:** these run once with an unbroken half_tick stream and once with a strobe that skips every third cycle. A stalled or wrongly tapped count shows up as a phase error.
- **Pulse mode:** each of the eight high-time codes is run over more than one full 8192-half-tick period. Pin 1 enters pulse mode 100 cycles after pin 0, which separates per-pin restart from a shared phase. The longer periods are run as well, some of them with a gapped strobe.
- **Alarm modes:** an irregular alarm pattern drives the toggle and copy codes. This separates edge detection from level following. Code 0 is then held against the same alarm activity.

// File: rtl/wo_pkg.sv
package wo_pkg;
  typedef enum logic [2:0] {
    SRC_LOW      = 3'd0,
    SRC_SQ1      = 3'd1,
    SRC_SQ32     = 3'd2,
    SRC_SQ64     = 3'd3,
    SRC_SQ512    = 3'd4,
    SRC_ALM_TGL  = 3'd5,
    SRC_ALM_COPY = 3'd6,
    SRC_PULSE    = 3'd7
  } src_e;

  // log2(one second in half-ticks / high time in half-ticks)
  function automatic int hi_drop(input logic [2:0] code);
    case (code)
      3'd0: hi_drop = 5;
      3'd1: hi_drop = 6;
      3'd2: hi_drop = 8;
      3'd3: hi_drop = 10;
      3'd4: hi_drop = 11;
      3'd5: hi_drop = 13;
      3'd6: hi_drop = 15;
      default: hi_drop = 16;
    endcase
  endfunction
endpackage

// File: rtl/wo_prescaler.sv
module wo_prescaler #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  output logic [CNT_W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (tick) cnt <= cnt + CNT_W'(1);
  end
endmodule

// File: rtl/wo_alarm_toggle.sv
module wo_alarm_toggle (
  input  logic clk,
  input  logic rst,
  input  logic alarm,
  output logic tog
);
  logic alarm_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      alarm_q <= 1'b0;
      tog     <= 1'b0;
    end else begin
      alarm_q <= alarm;
      if (alarm && !alarm_q) tog <= !tog;
    end
  end
endmodule

// File: rtl/wo_pulse_phase.sv
module wo_pulse_phase #(
  parameter int CNT_W = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       en,
  input  logic [2:0] hi_code,
  input  logic [1:0] per_code,
  output logic       lvl
);
  import wo_pkg::*;
  localparam int HW = CNT_W + 1;

  logic [CNT_W-1:0] ph;
  logic [CNT_W-1:0] last;
  logic [HW-1:0]    hlen;

  assign last = {CNT_W{1'b1}} >> per_code;
  assign hlen = HW'(1) << (CNT_W - hi_drop(hi_code));

  always_ff @(posedge clk) begin
    if (rst || !en)  ph <= '0;
    else if (tick)   ph <= (ph >= last) ? '0 : ph + CNT_W'(1);
  end

  assign lvl = en && ({1'b0, ph} < hlen);
endmodule

// File: rtl/wo_pin_mux.sv
module wo_pin_mux #(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  wo_pkg::src_e      sel,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              alarm,
  input  logic              tog,
  input  logic              pulse_lvl,
  output logic              pin
);
  import wo_pkg::*;
  localparam int B_1HZ   = CNT_W - 1;
  localparam int B_32HZ  = CNT_W - 6;
  localparam int B_64HZ  = CNT_W - 7;
  localparam int B_512HZ = CNT_W - 10;

  always_ff @(posedge clk) begin
    if (rst) pin <= 1'b0;
    else begin
      case (sel)
        SRC_SQ1:      pin <= cnt[B_1HZ];
        SRC_SQ32:     pin <= cnt[B_32HZ];
        SRC_SQ64:     pin <= cnt[B_64HZ];
        SRC_SQ512:    pin <= cnt[B_512HZ];
        SRC_ALM_TGL:  pin <= tog;
        SRC_ALM_COPY: pin <= alarm;
        SRC_PULSE:    pin <= pulse_lvl;
        default:      pin <= 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/rtc_wave_out.sv
module rtc_wave_out #(
  parameter int CNT_W  = 16,
  parameter int N_PINS = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       half_tick,
  input  logic       alarm_flag,
  input  logic [2:0] src_sel0,
  input  logic [2:0] src_sel1,
  input  logic [2:0] hi_code,
  input  logic [1:0] per_code,
  output logic       pin_out0,
  output logic       pin_out1
);
  import wo_pkg::*;

  logic [CNT_W-1:0] cnt;
  logic             tog;
  logic [2:0]       sel_a [N_PINS];
  logic             pin_a [N_PINS];

  assign sel_a[0] = src_sel0;
  assign sel_a[1] = src_sel1;
  assign pin_out0 = pin_a[0];
  assign pin_out1 = pin_a[1];

  wo_prescaler #(.CNT_W(CNT_W)) i_pre (
    .clk(clk), .rst(rst), .tick(half_tick), .cnt(cnt)
  );

  wo_alarm_toggle i_tgl (
    .clk(clk), .rst(rst), .alarm(alarm_flag), .tog(tog)
  );

  for (genvar g = 0; g < N_PINS; g++) begin : g_pin
    src_e sel;
    logic lvl;
    assign sel = src_e'(sel_a[g]);

    wo_pulse_phase #(.CNT_W(CNT_W)) i_pulse (
      .clk(clk), .rst(rst), .tick(half_tick), .en(sel == SRC_PULSE),
      .hi_code(hi_code), .per_code(per_code), .lvl(lvl)
    );

    wo_pin_mux #(.CNT_W(CNT_W)) i_mux (
      .clk(clk), .rst(rst), .sel(sel), .cnt(cnt), .alarm(alarm_flag),
      .tog(tog), .pulse_lvl(lvl), .pin(pin_a[g])
    );
  end
endmodule

// File: rtl/rtc_wave_out_chk.sv
module rtc_wave_out_chk (
  input logic       clk,
  input logic       rst,
  input logic       half_tick,
  input logic       alarm_flag,
  input logic [2:0] src_sel0,
  input logic [2:0] src_sel1,
  input logic       pin_out0,
  input logic       pin_out1
);
  logic [2:0] sel [2];
  logic       pin [2];
  assign sel[0] = src_sel0;
  assign sel[1] = src_sel1;
  assign pin[0] = pin_out0;
  assign pin[1] = pin_out1;

  for (genvar g = 0; g < 2; g++) begin : g_chk
    p_zero_low_r1: assert property (@(posedge clk) disable iff (rst)
      sel[g] == 3'd0 |=> !pin[g]);

    p_copy_alarm_r3: assert property (@(posedge clk) disable iff (rst)
      sel[g] == 3'd6 |=> pin[g] == $past(alarm_flag));

    p_toggle_edge_r4: assert property (@(posedge clk) disable iff (rst)
      (sel[g] == 3'd5 && $past(sel[g]) == 3'd5 && $past($rose(alarm_flag)))
      |=> pin[g] != $past(pin[g]));

    p_pulse_restart_r8: assert property (@(posedge clk) disable iff (rst)
      (sel[g] == 3'd7 && $past(sel[g]) != 3'd7) |=> pin[g]);

    p_hold_no_tick_r10: assert property (@(posedge clk) disable iff (rst)
      (sel[g] >= 3'd1 && sel[g] <= 3'd4 && $past(sel[g]) == sel[g] &&
       !$past(half_tick)) |=> pin[g] == $past(pin[g]));
  end
endmodule

bind rtc_wave_out rtc_wave_out_chk i_chk (
  .clk(clk), .rst(rst), .half_tick(half_tick), .alarm_flag(alarm_flag),
  .src_sel0(src_sel0), .src_sel1(src_sel1),
  .pin_out0(pin_out0), .pin_out1(pin_out1)
);

// File: tb/test_rtc_wave_out.sv
module test_rtc_wave_out;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       half_tick = 1'b0;
  logic       alarm_flag = 1'b0;
  logic [2:0] src_sel0 = 3'd0;
  logic [2:0] src_sel1 = 3'd0;
  logic [2:0] hi_code = 3'd0;
  logic [1:0] per_code = 2'd0;
  logic       pin_out0, pin_out1;

  int checks = 0;
  int errors = 0;
  int tick_mode = 0;
  int cyc = 0;
  bit done = 0;

  always #4 clk = ~clk;

  rtc_wave_out i_rtc_wave_out (
    .clk(clk), .rst(rst), .half_tick(half_tick), .alarm_flag(alarm_flag),
    .src_sel0(src_sel0), .src_sel1(src_sel1), .hi_code(hi_code),
    .per_code(per_code), .pin_out0(pin_out0), .pin_out1(pin_out1)
  );

  // Reference state built from the requirements
  int n, nd;
  int k [2];
  int kd [2];
  bit aq, tg, tgd, ad;

  always @(posedge clk) begin
    if (rst) begin
      n <= 0; nd <= 0; aq <= 0; tg <= 0; tgd <= 0; ad <= 0;
      k[0] <= 0; k[1] <= 0; kd[0] <= 0; kd[1] <= 0;
    end else begin
      n   <= n + int'(half_tick);
      nd  <= n;
      aq  <= alarm_flag;
      tg  <= tg ^ (alarm_flag & ~aq);
      tgd <= tg;
      ad  <= alarm_flag;
      k[0] <= (src_sel0 != 3'd7) ? 0 : k[0] + int'(half_tick);
      k[1] <= (src_sel1 != 3'd7) ? 0 : k[1] + int'(half_tick);
      kd[0] <= k[0];
      kd[1] <= k[1];
    end
  end

  function automatic int h_len(input int c);
    case (c)
      0: return 2048; 1: return 1024; 2: return 256; 3: return 64;
      4: return 32;   5: return 8;    6: return 2;   default: return 1;
    endcase
  endfunction

  function automatic bit expect_pin(input int s, input int kk);
    int p;
    p = 65536 >> per_code;
    case (s)
      0: return 1'b0;
      1: return ((nd / 32768) % 2) == 1;
      2: return ((nd / 1024) % 2) == 1;
      3: return ((nd / 512) % 2) == 1;
      4: return ((nd / 64) % 2) == 1;
      5: return tgd;
      6: return ad;
      default: return (kk % p) < h_len(int'(hi_code));
    endcase
  endfunction

  function automatic string tag_of(input int s);
    case (s)
      0: return "R1 R9";
      1, 2, 3, 4: return "R2 R9 R10";
      5: return "R4 R9";
      6: return "R3 R9";
      default: return "R5 R6 R7 R8 R9 R10";
    endcase
  endfunction

  always @(negedge clk) begin
    if (!rst && !done) begin
      for (int p = 0; p < 2; p++) begin
        int s;
        bit e, a;
        s = (p == 0) ? int'(src_sel0) : int'(src_sel1);
        a = (p == 0) ? pin_out0 : pin_out1;
        e = expect_pin(s, kd[p]);
        checks++;
        if (a !== e) begin
          errors++;
          if (errors < 20)
            $display("FAIL %s pin%0d code %0d at t=%0t: got %0b expected %0b",
                     tag_of(s), p, s, $time, a, e);
        end
      end
    end
  end

  task automatic run(input int cycles);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      #1;
      cyc++;
      case (tick_mode)
        0: half_tick = 1'b1;
        1: half_tick = (cyc % 3) != 0;
        default: half_tick = ((cyc * 13) % 7) < 4;
      endcase
    end
  endtask

  task automatic finish_run();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired: got hung run expected completion");
    finish_run();
  end

  initial begin
    src_sel0 = 3'd1;
    src_sel1 = 3'd6;
    repeat (4) @(negedge clk);
    // R1: reset state
    checks++;
    if (pin_out0 !== 1'b0 || pin_out1 !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset: got %0b%0b expected 00", pin_out0, pin_out1);
    end
    #1 rst = 1'b0;

    // R2: square waves, continuous strobe, one full 1 Hz half period
    tick_mode = 0;
    src_sel0 = 3'd1; src_sel1 = 3'd2;
    run(33000);
    // R2 R10: faster squares with a gapped strobe
    tick_mode = 1;
    src_sel0 = 3'd3; src_sel1 = 3'd4;
    run(3000);

    // R5 R6 R8 R9: every high-time code, pin 1 enters later
    tick_mode = 0;
    per_code = 2'd3;
    for (int h = 0; h < 8; h++) begin
      src_sel0 = 3'd0; src_sel1 = 3'd4;
      run(2);
      hi_code = 3'(h);
      src_sel0 = 3'd7;
      run(100);
      src_sel1 = 3'd7;
      run(8400);
    end

    // R7: longer periods
    src_sel0 = 3'd0; src_sel1 = 3'd0;
    run(2);
    per_code = 2'd2; hi_code = 3'd0;
    src_sel0 = 3'd7; src_sel1 = 3'd7;
    run(16600);
    src_sel0 = 3'd0; src_sel1 = 3'd2;
    run(2);
    tick_mode = 2;
    per_code = 2'd1; hi_code = 3'd2;
    src_sel0 = 3'd7;
    run(3000);
    src_sel0 = 3'd0;
    run(2);
    per_code = 2'd0; hi_code = 3'd1;
    src_sel0 = 3'd7; src_sel1 = 3'd3;
    run(3000);

    // R3 R4: alarm-driven codes with an irregular alarm pattern
    src_sel0 = 3'd5; src_sel1 = 3'd6;
    run(3);
    for (int i = 0; i < 400; i++) begin
      alarm_flag = ((i * 7) % 5) < 2 || (i % 11) == 0;
      run(1);
    end
    // R1: code 0 against the same alarm activity
    src_sel0 = 3'd0; src_sel1 = 3'd5;
    for (int i = 0; i < 200; i++) begin
      alarm_flag = ((i * 3) % 7) < 3;
      run(1);
    end
    run(4);
    finish_run();
  end
endmodule